// File: doc/BRIEF.md
# Live register state transfer helper

This block moves the contents of a running, clock-enabled register cell into a spare replica cell without stopping the system clock. Once the copy is done, the original cell can be taken out of service and tested. A free-running register would not need this block: its replica could simply share the same data inputs and would pick up the same state. A register with a clock enable can sit idle for any length of time, so the replica has to be loaded through a side path.

A relocation controller outside this block drives two strobes, a bypass strobe and a capture strobe. The legal order is:

1. Raise both strobes together.
2. Drop the capture strobe.
3. Drop the bypass strobe.

While both strobes are high, the replica is force-loaded. While only the bypass strobe is high, the replica follows the shared data and enable inputs. Once both strobes are low, the two cells run in lockstep.

After the two cells have agreed for one clock, the block finishes the handover on its own, one step per clock:

- Both cells drive the merged output together.
- The original cell's output is dropped, so the merged output now comes from the replica.
- The original cell's inputs are disconnected, which frees the cell for test.

A strobe sequence that breaks the legal order aborts the transfer. A compare flag watches the two cells for any disagreement while both are connected.

Top module: `xfer_state_helper`

## Requirements
- R1: During and directly after synchronous reset, `orig_q`, `replica_q`, `merged_q`, `done`, `mismatch` and `seq_err` are all zero.
- R2: In the idle phase, the original cell loads `orig_d` on every edge where `orig_ce` is 1 and holds otherwise. The replica holds its value. `merged_q` equals `orig_q`.
- R3: At every edge where both strobes are high, in the idle or copy phase, the replica loads the value the original holds after that same edge. That value is `orig_d` when `orig_ce` is 1 and `orig_q` when it is 0, so the load happens regardless of the enable.
- R4: With only the bypass strobe high after a copy, the replica loads `orig_d` exactly on the edges where `orig_ce` is 1, in step with the original.
- R5: The first edge that sees both strobes low after the bypass-only step enters the tied phase. `done` rises on the next edge that starts with both Q values equal. It then stays 1 until reset.
- R6: `merged_q` equals `orig_q` before `done`. In the cycle where `done` first reads 1, it is the bitwise AND of both cells' outputs. From the following cycle on, it equals `replica_q`.
- R7: From the fourth edge after the one that entered the tied phase, `orig_q` is frozen whatever `orig_ce` and `orig_d` do. The replica keeps loading `orig_d` when `orig_ce` is 1.
- R8: Any of the following aborts the transfer:
  - one strobe rising alone in the idle phase;
  - the bypass strobe low during the copy phase;
  - the capture strobe high during the bypass-only phase.
  On an abort, the block returns to idle with the replica holding its value. `seq_err` is 1 for exactly the one cycle after the offending edge. A new legal sequence can then be started.
- R9: `mismatch` is 1 only while both cells are connected (the bypass-only phase through the phase where the original's output is dropped) and their outputs differ.
- R10: Once the tied phase is reached, the strobes have no effect on any output until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| orig_d | input | WIDTH | Data input shared by both cells |
| orig_ce | input | 1 | Clock enable shared by both cells |
| bypass_copy | input | 1 | Bypass strobe from the relocation controller |
| capture_copy | input | 1 | Capture strobe from the relocation controller |
| orig_q | output | WIDTH | Original cell output |
| replica_q | output | WIDTH | Replica cell output |
| merged_q | output | WIDTH | Handover output, driven by either cell |
| done | output | 1 | Transfer complete; replica is in step with the original |
| mismatch | output | 1 | Disagreement between the connected cells |
| seq_err | output | 1 | One-cycle pulse on an illegal strobe order |

## Verification
The bench loads the replica with the enable both high and low on the loading edge. A design that copied the stale Q would fall one value behind whenever the enable was high. Each illegal strobe order is hit from every phase where it can occur, followed by a recovery sequence; a design that missed an abort would report `done` without a real copy. After release, the bench toggles the enable and the strobes so that an original cell left connected, or a late merged-output switch, would show up as a wrong `orig_q` or `merged_q` value.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_COPY = 3'd1,
        PH_HOLD = 3'd2,
        PH_TIED = 3'd3,
        PH_PAR  = 3'd4,
        PH_HAND = 3'd5,
        PH_REL  = 3'd6
    } phase_t;

    typedef enum logic [1:0] {
        RS_HOLD  = 2'd0,
        RS_LOAD  = 2'd1,
        RS_TRACK = 2'd2
    } rsel_t;

    typedef struct packed {
        rsel_t rsel;
        logic  orig_en;
        logic  connected;
        logic  rep_drives;
        logic  both_drive;
    } ctrl_t;

    function automatic logic phase_done(input phase_t p);
        return (p == PH_PAR) || (p == PH_HAND) || (p == PH_REL);
    endfunction

    function automatic logic phase_connected(input phase_t p);
        return (p == PH_HOLD) || (p == PH_TIED) || (p == PH_PAR) || (p == PH_HAND);
    endfunction

endpackage

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bypass,
    input  logic   capture,
    input  logic   q_match,
    output phase_t phase,
    output ctrl_t  ctrl,
    output logic   seq_err
);

    phase_t phase_nx;
    logic   err_nx;
    rsel_t  rsel_c;

    always_comb begin
        phase_nx = phase;
        err_nx   = 1'b0;
        rsel_c   = RS_HOLD;
        unique case (phase)
            PH_IDLE: begin
                if (bypass && capture) begin
                    phase_nx = PH_COPY;
                    rsel_c   = RS_LOAD;
                end else if (bypass || capture) begin
                    err_nx   = 1'b1;
                end
            end
            PH_COPY: begin
                if (bypass && capture) begin
                    rsel_c   = RS_LOAD;
                end else if (bypass) begin
                    phase_nx = PH_HOLD;
                    rsel_c   = RS_TRACK;
                end else begin
                    phase_nx = PH_IDLE;
                    err_nx   = 1'b1;
                end
            end
            PH_HOLD: begin
                if (capture) begin
                    phase_nx = PH_IDLE;
                    err_nx   = 1'b1;
                end else begin
                    rsel_c   = RS_TRACK;
                    if (!bypass) phase_nx = PH_TIED;
                end
            end
            PH_TIED: begin
                rsel_c = RS_TRACK;
                if (q_match) phase_nx = PH_PAR;
            end
            PH_PAR: begin
                rsel_c   = RS_TRACK;
                phase_nx = PH_HAND;
            end
            PH_HAND: begin
                rsel_c   = RS_TRACK;
                phase_nx = PH_REL;
            end
            PH_REL: begin
                rsel_c   = RS_TRACK;
            end
            default: begin
                phase_nx = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            seq_err <= 1'b0;
        end else begin
            phase   <= phase_nx;
            seq_err <= err_nx;
        end
    end

    always_comb begin
        ctrl.rsel       = rsel_c;
        ctrl.orig_en    = (phase != PH_REL);
        ctrl.connected  = phase_connected(phase);
        ctrl.rep_drives = (phase == PH_HAND) || (phase == PH_REL);
        ctrl.both_drive = (phase == PH_PAR);
    end

    assert_err_returns_idle_R8: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> (phase == PH_IDLE));

    assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        phase_done(phase) |=> phase_done(phase));

    assert_strobes_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        phase_done(phase) |=> !seq_err);

endmodule

// File: rtl/xfer_cell.sv
module xfer_cell #(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    input  logic             ce,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= RESET_VAL;
        else if (load) q <= load_val;
        else if (ce)   q <= d;
    end

endmodule

// File: rtl/xfer_outmux.sv
module xfer_outmux
    import xfer_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  ctrl_t            ctrl,
    input  logic [WIDTH-1:0] orig_q,
    input  logic [WIDTH-1:0] rep_q,
    output logic [WIDTH-1:0] merged_q,
    output logic             mismatch
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            if (ctrl.both_drive)      merged_q[b] = orig_q[b] & rep_q[b];
            else if (ctrl.rep_drives) merged_q[b] = rep_q[b];
            else                      merged_q[b] = orig_q[b];
        end
    end

    assign mismatch = ctrl.connected && (orig_q != rep_q);

endmodule

// File: rtl/xfer_state_helper.sv
module xfer_state_helper
    import xfer_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] orig_d,
    input  logic             orig_ce,
    input  logic             bypass_copy,
    input  logic             capture_copy,
    output logic [WIDTH-1:0] orig_q,
    output logic [WIDTH-1:0] replica_q,
    output logic [WIDTH-1:0] merged_q,
    output logic             done,
    output logic             mismatch,
    output logic             seq_err
);

    phase_t           phase;
    ctrl_t            ctrl;
    logic             orig_ce_eff;
    logic [WIDTH-1:0] orig_next;

    xfer_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .bypass  (bypass_copy),
        .capture (capture_copy),
        .q_match (orig_q == replica_q),
        .phase   (phase),
        .ctrl    (ctrl),
        .seq_err (seq_err)
    );

    assign orig_ce_eff = ctrl.orig_en && orig_ce;
    assign orig_next   = orig_ce_eff ? orig_d : orig_q;

    xfer_cell #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_orig (
        .clk      (clk),
        .rst      (rst),
        .d        (orig_d),
        .ce       (orig_ce_eff),
        .load     (1'b0),
        .load_val (orig_d),
        .q        (orig_q)
    );

    xfer_cell #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_rep (
        .clk      (clk),
        .rst      (rst),
        .d        (orig_d),
        .ce       ((ctrl.rsel == RS_TRACK) && orig_ce),
        .load     (ctrl.rsel == RS_LOAD),
        .load_val (orig_next),
        .q        (replica_q)
    );

    xfer_outmux #(.WIDTH(WIDTH)) u_out (
        .ctrl     (ctrl),
        .orig_q   (orig_q),
        .rep_q    (replica_q),
        .merged_q (merged_q),
        .mismatch (mismatch)
    );

    assign done = phase_done(phase);

    assert_copy_lands_R3: assert property (@(posedge clk) disable iff (rst)
        (bypass_copy && capture_copy && (phase == PH_IDLE || phase == PH_COPY))
        |=> (replica_q == orig_q));

    assert_released_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REL) |=> $stable(orig_q));

    assert_replica_drives_R6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HAND || phase == PH_REL) |-> (merged_q == replica_q));

    assert_done_means_equal_R5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAR || phase == PH_HAND) |-> (orig_q == replica_q));

    assert_no_mismatch_R9: assert property (@(posedge clk) disable iff (rst)
        !mismatch);

endmodule

// File: tb/sim_xfer_state_helper.sv
module sim_xfer_state_helper;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] d;
    logic         ce, byp, cap;
    logic [W-1:0] orig_q, replica_q, merged_q;
    logic         done, mismatch, seq_err;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    // bench model: 0 idle,1 copy,2 hold,3 tied,4 parallel,5 handed,6 released
    int           m_ph;
    logic [W-1:0] m_orig, m_rep;
    logic         m_err;

    always #4 clk = ~clk;

    xfer_state_helper #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .orig_d(d), .orig_ce(ce),
        .bypass_copy(byp), .capture_copy(cap),
        .orig_q(orig_q), .replica_q(replica_q), .merged_q(merged_q),
        .done(done), .mismatch(mismatch), .seq_err(seq_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; d = '0; ce = 1'b0; byp = 1'b0; cap = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        chk("R1 orig_q", orig_q, 0);
        chk("R1 replica_q", replica_q, 0);
        chk("R1 merged_q", merged_q, 0);
        chk("R1 done", done, 0);
        chk("R1 mismatch", mismatch, 0);
        chk("R1 seq_err", seq_err, 0);
        @(negedge clk);
        rst = 1'b0;
        m_ph = 0; m_orig = '0; m_rep = '0; m_err = 1'b0;
    endtask

    task automatic step(input logic [W-1:0] vd, input logic vce, input logic vb,
                        input logic vc, input string tag);
        logic [W-1:0] onext, rnext;
        int           pnext;
        logic         enext;
        @(negedge clk);
        d = vd; ce = vce; byp = vb; cap = vc;
        onext = (m_ph != 6 && vce) ? vd : m_orig;
        rnext = m_rep;
        pnext = m_ph;
        enext = 1'b0;
        case (m_ph)
            0: if (vb && vc) begin pnext = 1; rnext = onext; end
               else if (vb || vc) enext = 1'b1;
            1: if (vb && vc) rnext = onext;
               else if (vb) begin pnext = 2; if (vce) rnext = vd; end
               else begin pnext = 0; enext = 1'b1; end
            2: if (vc) begin pnext = 0; enext = 1'b1; end
               else begin if (vce) rnext = vd; if (!vb) pnext = 3; end
            3: begin if (vce) rnext = vd; if (m_orig == m_rep) pnext = 4; end
            4: begin if (vce) rnext = vd; pnext = 5; end
            default: begin if (vce) rnext = vd; pnext = 6; end
        endcase
        @(posedge clk);
        m_orig = onext; m_rep = rnext; m_ph = pnext; m_err = enext;
        #2;
        chk({tag, " orig_q (R2/R7)"}, orig_q, m_orig);
        chk({tag, " replica_q (R3/R4)"}, replica_q, m_rep);
        chk({tag, " merged_q R6"}, merged_q,
            (m_ph < 4) ? m_orig : (m_ph == 4) ? (m_orig & m_rep) : m_rep);
        chk({tag, " done R5"}, done, (m_ph >= 4));
        chk({tag, " seq_err R8"}, seq_err, m_err);
        chk({tag, " mismatch R9"}, mismatch, 0);
    endtask

    task automatic full_copy(input logic [W-1:0] seed);
        for (int i = 0; i < 2 * (1 << W); i++)
            step(W'(i) ^ seed, i[0], 1'b1, 1'b1, "R3 copy");
        for (int i = 0; i < 2 * (1 << W); i++)
            step(W'(i * 3) ^ seed, i[1], 1'b1, 1'b0, "R4 bypass");
        step(seed, 1'b1, 1'b0, 1'b0, "R5 tie");
    endtask

    initial begin
        rst = 1'b1; d = '0; ce = 1'b0; byp = 1'b0; cap = 1'b0;
        do_reset();

        for (int i = 0; i < 2 * (1 << W); i++)
            step(W'(i >> 1), i[0], 1'b0, 1'b0, "R2 idle");

        full_copy(4'h9);
        for (int i = 0; i < 3; i++) step(W'(i + 1), 1'b1, 1'b0, 1'b0, "R5 handover");
        for (int i = 0; i < 64; i++)
            step(W'(i * 5), i[2], i[3], i[4], "R7 R10 released");

        do_reset();
        step(4'h3, 1'b1, 1'b0, 1'b1, "R8 capture alone");
        step(4'h4, 1'b1, 1'b1, 1'b0, "R8 bypass alone");
        step(4'h7, 1'b0, 1'b1, 1'b1, "R3 copy");
        step(4'h9, 1'b1, 1'b0, 1'b1, "R8 bypass low in copy");
        step(4'h2, 1'b1, 1'b0, 1'b0, "R8 idle after abort");
        step(4'hA, 1'b1, 1'b1, 1'b1, "R3 copy");
        step(4'hB, 1'b1, 1'b1, 1'b0, "R4 bypass");
        step(4'hC, 1'b1, 1'b1, 1'b1, "R8 capture back in bypass");
        step(4'hD, 1'b0, 1'b0, 1'b0, "R8 idle after abort");

        full_copy(4'h6);
        for (int i = 0; i < 40; i++)
            step(W'(i ^ 5), i[0], i[1], i[2], "R10 after recovery");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule